// File: doc/BRIEF.md
# Serial bus command framer

This block builds master command frames for a two-wire management bus and sends them. The bus has one clock line and one data line that is driven in both directions. A request names a slave, an operation, an address, a transfer size and write data. Four operations are supported: read, write, data-poll and terminate.

The framer assembles the frame bits and sends a start bit first. It then shifts out the frame, most significant bit first, with one bus clock pulse per bit. Each pulse is a low phase followed by a high phase. The line is active-low. The framer computes a 4-bit check code serially while the bits go out and appends it. It then holds the data line idle for a fixed number of echo-delay clocks. A one-cycle completion pulse follows, and the framer is ready again in that same cycle.

Response capture and retry belong to a neighbouring block. The bus clock rate is set by a parameter giving the length of each phase in system clocks.

Top module: `sbf_cmd_framer`

## Requirements
- R1: After synchronous reset the outputs are as follows: `bus_clk` high, `bus_data` high, `bus_drive` low, `req_ready` high and `done` low.
- R2: For a read (`req_op`=0) or a write (`req_op`=1), the logical frame is sent in this order:
  - slave id, 2 bits;
  - opcode 3'b100;
  - direction bit, 1 for read and 0 for write;
  - address, 21 bits;
  - size bit.
- R3: A write appends its data bytes after the size bit. They are taken from the low 8, 16 or 32 bits of `req_wdata` and sent most significant byte first, each byte MSB first.
- R4: Size code 0 means 1 byte: the size bit is 0 and the address is unchanged. Code 1 means 2 bytes: address bit 0 is cleared and the size bit is 1. Codes 2 and 3 mean 4 bytes: address bits [1:0] are forced to 2'b01 and the size bit is 1.
- R5: A data-poll (`req_op`=2) frame is the 2-bit slave id followed by 3'b010.
- R6: A terminate (`req_op`=3) frame is the 2-bit slave id followed by 6'b111111.
- R7: Four check bits follow the frame, MSB first. They are the x^4+x+1 remainder, seeded with 0, of a logical 1 start bit and the frame bits. The register is shifted as c = {c[2:0],0} ^ (c[3]^b ? 4'b0011 : 0). Running the same register over start, frame and check bits leaves zero.
- R8: Every logical bit, the start bit included, is driven inverted on `bus_data`. Each bit gets one `bus_clk` pulse: low for HALF_DIV clocks, then high for HALF_DIV clocks. Data changes only when `bus_clk` falls.
- R9: After the check bits, ECHO_CLKS (16) further bus clocks are sent with logical 0 (line high).
- R10: `bus_drive` is high from acceptance to the end of the last echo clock, and low whenever the framer is idle. `bus_clk` is only low while `bus_drive` is high.
- R11: A request is accepted only when `req_valid` and `req_ready` are both high. While a frame is in progress `req_ready` is low, and `req_valid` together with other inputs has no effect on the frame sent.
- R12: `done` is a one-cycle pulse in the cycle after the last echo clock's high phase. `req_ready` is high in that same cycle, so a new request can be accepted there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Framer idle and able to accept |
| req_id | input | 2 | Slave id |
| req_op | input | 2 | 0 read, 1 write, 2 data-poll, 3 terminate |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 2 | 0: 1 byte, 1: 2 bytes, 2/3: 4 bytes |
| req_wdata | input | DATA_W | Write data, low bytes used |
| done | output | 1 | One-cycle completion pulse |
| bus_clk | output | 1 | Bus clock, idles high |
| bus_data | output | 1 | Bus data, active-low |
| bus_drive | output | 1 | Level-translator direction, high while driving |

## Verification
Two things can happen in the same system clock cycle: the completion pulse of one frame and the acceptance of the next request. The bench provokes this by keeping `req_valid` high through a whole write. It presents the next request at the moment the framer reports ready, which is the `done` cycle. This is judged correct when:
- each frame captured from the bus matches its expected bit stream;
- `done` lasts exactly one cycle;
- the number of frames seen equals the number of requests queued.

A separate case raises `req_valid` with different inputs in the middle of a frame, to show it has no effect.

// File: rtl/sbf_pkg.sv
package sbf_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_POLL  = 2'd2,
    OP_TERM  = 2'd3
  } op_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_SEND = 1'b1
  } state_e;

  localparam int ID_W      = 2;
  localparam int CRC_W     = 4;
  localparam logic [2:0] OPC_ABS  = 3'b100;
  localparam logic [2:0] OPC_POLL = 3'b010;
  localparam logic [5:0] OPC_TERM = 6'b111111;
endpackage

// File: rtl/sbf_frame_build.sv
module sbf_frame_build
  import sbf_pkg::*;
#(
  parameter int ADDR_W = 21,
  parameter int DATA_W = 32,
  localparam int HDR_W = ID_W + 3 + 1 + ADDR_W + 1,
  localparam int FW    = HDR_W + DATA_W,
  localparam int LEN_W = $clog2(FW + 1)
) (
  input  logic [ID_W-1:0]   id,
  input  logic [1:0]        op,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  input  logic [DATA_W-1:0] wdata,
  output logic [FW-1:0]     frame,
  output logic [LEN_W-1:0]  len
);
  int                nbytes;
  logic [ADDR_W-1:0] a_fix;
  logic              sz_bit;
  logic [HDR_W-1:0]  hdr;
  logic [DATA_W-1:0] data_al;

  always_comb begin
    a_fix  = addr;
    sz_bit = 1'b0;
    nbytes = 1;
    case (size)
      2'd0: nbytes = 1;
      2'd1: begin
        nbytes   = 2;
        a_fix[0] = 1'b0;
        sz_bit   = 1'b1;
      end
      default: begin
        nbytes     = 4;
        a_fix[1:0] = 2'b01;
        sz_bit     = 1'b1;
      end
    endcase
    hdr     = {id, OPC_ABS, (op == OP_READ), a_fix, sz_bit};
    data_al = wdata << (DATA_W - 8 * nbytes);
    case (op_e'(op))
      OP_READ: begin
        frame = {hdr, {DATA_W{1'b0}}};
        len   = LEN_W'(HDR_W);
      end
      OP_WRITE: begin
        frame = {hdr, data_al};
        len   = LEN_W'(HDR_W + 8 * nbytes);
      end
      OP_POLL: begin
        frame = {id, OPC_POLL, {(FW - ID_W - 3){1'b0}}};
        len   = LEN_W'(ID_W + 3);
      end
      default: begin
        frame = {id, OPC_TERM, {(FW - ID_W - 6){1'b0}}};
        len   = LEN_W'(ID_W + 6);
      end
    endcase
  end
endmodule

// File: rtl/sbf_crc4.sv
module sbf_crc4
  import sbf_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic step_en,
  input  logic step_bit,
  input  logic shift_en,
  output logic msb
);
  logic [CRC_W-1:0] crc_q;
  logic             fb;

  assign fb  = crc_q[CRC_W-1] ^ step_bit;
  assign msb = crc_q[CRC_W-1];

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      crc_q <= '0;
    end else if (step_en) begin
      crc_q <= {crc_q[CRC_W-2:0], 1'b0} ^ {2'b00, fb, fb};
    end else if (shift_en) begin
      crc_q <= {crc_q[CRC_W-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/sbf_bit_timer.sv
module sbf_bit_timer #(
  parameter int HALF_DIV = 2,
  localparam int PER = 2 * HALF_DIV,
  localparam int CW  = $clog2(PER)
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic run,
  output logic t_fall,
  output logic t_rise,
  output logic t_end
);
  logic [CW-1:0] cnt_q;

  assign t_fall = run && (cnt_q == CW'(0));
  assign t_rise = run && (cnt_q == CW'(HALF_DIV));
  assign t_end  = run && (cnt_q == CW'(PER - 1));

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt_q <= '0;
    end else if (run) begin
      cnt_q <= t_end ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/sbf_cmd_framer.sv
module sbf_cmd_framer
  import sbf_pkg::*;
#(
  parameter int ADDR_W    = 21,
  parameter int DATA_W    = 32,
  parameter int HALF_DIV  = 2,
  parameter int ECHO_CLKS = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_id,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              done,
  output logic              bus_clk,
  output logic              bus_data,
  output logic              bus_drive
);
  localparam int HDR_W = ID_W + 3 + 1 + ADDR_W + 1;
  localparam int FW    = HDR_W + DATA_W;
  localparam int LEN_W = $clog2(FW + 1);
  localparam int NMAX  = 1 + FW + CRC_W + ECHO_CLKS;
  localparam int IDX_W = $clog2(NMAX + 1);

  state_e            state_q;
  logic [FW-1:0]     sh_q;
  logic [LEN_W-1:0]  len_q;
  logic [IDX_W-1:0]  idx_q;
  logic              clk_q, data_q, drive_q, done_q;

  logic [FW-1:0]     frame_w;
  logic [LEN_W-1:0]  len_w;
  logic              accept;
  logic              t_fall, t_rise, t_end;
  logic              crc_msb;
  logic [IDX_W-1:0]  len_x;
  logic              in_start, in_pay, in_crc, is_last;
  logic              cur_bit;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_ready && req_valid;
  assign done      = done_q;
  assign bus_clk   = clk_q;
  assign bus_data  = data_q;
  assign bus_drive = drive_q;

  sbf_frame_build #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_build (
    .id(req_id), .op(req_op), .addr(req_addr), .size(req_size),
    .wdata(req_wdata), .frame(frame_w), .len(len_w)
  );

  sbf_bit_timer #(.HALF_DIV(HALF_DIV)) u_timer (
    .clk(clk), .rst(rst), .restart(accept), .run(state_q == ST_SEND),
    .t_fall(t_fall), .t_rise(t_rise), .t_end(t_end)
  );

  always_comb begin
    len_x    = IDX_W'(len_q);
    in_start = (idx_q == '0);
    in_pay   = !in_start && (idx_q <= len_x);
    in_crc   = (idx_q > len_x) && (idx_q <= len_x + IDX_W'(CRC_W));
    is_last  = (idx_q == len_x + IDX_W'(CRC_W + ECHO_CLKS));
    if (in_start)    cur_bit = 1'b1;
    else if (in_pay) cur_bit = sh_q[FW-1];
    else if (in_crc) cur_bit = crc_msb;
    else             cur_bit = 1'b0;
  end

  sbf_crc4 u_crc (
    .clk(clk), .rst(rst), .clr(accept),
    .step_en(t_fall && (in_start || in_pay)), .step_bit(cur_bit),
    .shift_en(t_fall && in_crc), .msb(crc_msb)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      sh_q    <= '0;
      len_q   <= '0;
      idx_q   <= '0;
      clk_q   <= 1'b1;
      data_q  <= 1'b1;
      drive_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            sh_q    <= frame_w;
            len_q   <= len_w;
            idx_q   <= '0;
            drive_q <= 1'b1;
            state_q <= ST_SEND;
          end
        end
        default: begin
          if (t_fall) begin
            clk_q  <= 1'b0;
            data_q <= ~cur_bit;
            if (in_pay) sh_q <= sh_q << 1;
          end
          if (t_rise) clk_q <= 1'b1;
          if (t_end) begin
            if (is_last) begin
              state_q <= ST_IDLE;
              drive_q <= 1'b0;
              done_q  <= 1'b1;
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/sbf_cmd_framer_chk.sv
module sbf_cmd_framer_chk #(
  parameter int ADDR_W = 21,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic [1:0]        req_id,
  input logic [1:0]        req_op,
  input logic [ADDR_W-1:0] req_addr,
  input logic [1:0]        req_size,
  input logic [DATA_W-1:0] req_wdata,
  input logic              done,
  input logic              bus_clk,
  input logic              bus_data,
  input logic              bus_drive
);
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R12
  AST_DONE_WITH_READY: assert property (@(posedge clk) disable iff (rst)
    done |-> (req_ready && !bus_drive && bus_clk)); // R12
  AST_DRIVE_RELEASE_DONE: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_drive) |-> done); // R10
  AST_IDLE_LINE: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (bus_clk && bus_data && !bus_drive)); // R10
  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (!req_ready && bus_drive)); // R11
  AST_CLK_LOW_DRIVEN: assert property (@(posedge clk) disable iff (rst)
    !bus_clk |-> bus_drive); // R8
  AST_DATA_AT_FALL: assert property (@(posedge clk) disable iff (rst)
    (bus_clk && $past(bus_clk)) |-> $stable(bus_data) || !bus_drive); // R8
endmodule

bind sbf_cmd_framer sbf_cmd_framer_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/sbf_cmd_framer_tb.sv
module sbf_cmd_framer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 2;
  localparam int ECHO = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_id = '0;
  logic [1:0]  req_op = '0;
  logic [20:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic [31:0] req_wdata = '0;
  logic        done, bus_clk, bus_data, bus_drive;

  always #(CLK_PERIOD / 2) clk = ~clk;

  sbf_cmd_framer #(.HALF_DIV(HALF), .ECHO_CLKS(ECHO)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_id(req_id), .req_op(req_op), .req_addr(req_addr),
    .req_size(req_size), .req_wdata(req_wdata), .done(done),
    .bus_clk(bus_clk), .bus_data(bus_data), .bus_drive(bus_drive)
  );

  typedef struct {
    logic [127:0] bits;
    int           n;
    int           plen;
    string        tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  int frames_seen = 0;
  int frames_sent = 0;

  task automatic chk(input bit ok, input string req, input string act, input string exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%s expected=%s", req, act, exp);
    end
  endtask

  function automatic logic [3:0] step4(input logic [3:0] c, input logic b);
    logic fb;
    fb = c[3] ^ b;
    return {c[2:0], 1'b0} ^ (fb ? 4'b0011 : 4'b0000);
  endfunction

  function automatic exp_t make_exp(input logic [1:0] id, input logic [1:0] op,
                                    input logic [20:0] addr, input logic [1:0] sz,
                                    input logic [31:0] wd, input string tag);
    exp_t e;
    logic [63:0] p;
    logic [20:0] a;
    logic s;
    logic [3:0] c;
    int nb, k;
    p = '0; a = addr;
    if (sz == 2'd0) begin nb = 1; s = 1'b0; end
    else if (sz == 2'd1) begin nb = 2; s = 1'b1; a[0] = 1'b0; end
    else begin nb = 4; s = 1'b1; a[1:0] = 2'b01; end
    if (op == 2'd2) begin p = {59'd0, id, 3'b010}; e.plen = 5; end
    else if (op == 2'd3) begin p = {56'd0, id, 6'b111111}; e.plen = 8; end
    else begin
      p = {36'd0, id, 3'b100, (op == 2'd0), a, s};
      e.plen = 28;
      if (op == 2'd1)
        for (int i = 0; i < nb; i++) begin
          p = (p << 8) | 64'((wd >> (8 * (nb - 1 - i))) & 32'hff);
          e.plen += 8;
        end
    end
    e.bits = '0;
    e.bits[0] = 1'b1;
    c = step4(4'd0, 1'b1);
    k = 1;
    for (int i = 0; i < e.plen; i++) begin
      e.bits[k] = p[e.plen - 1 - i];
      c = step4(c, p[e.plen - 1 - i]);
      k++;
    end
    for (int i = 3; i >= 0; i--) begin
      e.bits[k] = c[i];
      k++;
    end
    e.n = k + ECHO;
    e.tag = tag;
    return e;
  endfunction

  // Driver
  task automatic send(input logic [1:0] id, input logic [1:0] op, input logic [20:0] addr,
                      input logic [1:0] sz, input logic [31:0] wd, input bit keep,
                      input string tag);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_id = id; req_op = op; req_addr = addr; req_size = sz; req_wdata = wd;
    req_valid = 1'b1;
    q.push_back(make_exp(id, op, addr, sz, wd, tag));
    frames_sent++;
    @(negedge clk);
    if (!keep) req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (q.size() != 0 || !req_ready) @(negedge clk);
  endtask

  // Monitor
  logic [127:0] rx = '0;
  int  rn = 0, lowcnt = 0;
  bit  prev_bclk = 1'b1, in_frame = 0, bad_phase = 0, bad_drive = 0, done_prev = 0;

  always @(negedge clk) begin
    if (!rst) begin
      if (done_prev) chk(!done, "R12 done width", $sformatf("%0b", done), "0");
      done_prev = done;
      if (bus_drive && !bus_clk) begin
        lowcnt++;
        in_frame = 1;
      end
      if (in_frame && !prev_bclk && bus_clk) begin
        if (lowcnt != HALF) bad_phase = 1;
        if (rn < 128) rx[rn] = ~bus_data;
        rn++;
        lowcnt = 0;
      end
      if (in_frame && !bus_drive && !done) bad_drive = 1;
      if (done) begin
        frames_seen++;
        if (q.size() == 0) begin
          chk(0, "R11 extra frame", $sformatf("%0d bits", rn), "none");
        end else begin
          exp_t e;
          logic [3:0] c;
          bit echo_ok;
          e = q.pop_front();
          chk(rn == e.n && rx == e.bits, {e.tag, " frame"},
              $sformatf("n=%0d %h", rn, rx), $sformatf("n=%0d %h", e.n, e.bits));
          c = 4'd0;
          for (int k = 0; k < 1 + e.plen + 4; k++) c = step4(c, rx[k]);
          chk(c == 4'd0, {"R7 residue ", e.tag}, $sformatf("%h", c), "0");
          echo_ok = (rn == e.n);
          for (int k = 1 + e.plen + 4; k < e.n; k++) if (rx[k]) echo_ok = 0;
          chk(echo_ok, {"R9 echo ", e.tag}, $sformatf("n=%0d", rn), $sformatf("n=%0d zeros", e.n));
          chk(!bad_phase, {"R8 phase ", e.tag}, "low phase mismatch", $sformatf("%0d", HALF));
          chk(!bad_drive, {"R10 drive ", e.tag}, "drive dropped", "held");
        end
        rx = '0; rn = 0; lowcnt = 0; in_frame = 0; bad_phase = 0; bad_drive = 0;
      end
      prev_bclk = bus_clk;
    end
  end

  // Watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(bus_clk && bus_data && !bus_drive && req_ready && !done, "R1 reset",
        $sformatf("%b%b%b%b%b", bus_clk, bus_data, bus_drive, req_ready, done), "11010");
    rst = 1'b0;
    repeat (2) @(negedge clk);

    send(2'd1, 2'd0, 21'h1ABCD, 2'd0, 32'h0, 0, "R2 R4 read1");
    wait_idle();
    send(2'd2, 2'd0, 21'h0F0F3, 2'd1, 32'h0, 0, "R4 read2");
    wait_idle();
    send(2'd3, 2'd0, 21'h1FFFF, 2'd2, 32'h0, 0, "R4 read4");
    wait_idle();
    send(2'd0, 2'd0, 21'h00002, 2'd3, 32'h0, 0, "R4 read4 code3");
    wait_idle();
    send(2'd1, 2'd1, 21'h12345, 2'd0, 32'hFFFF_FF5A, 0, "R3 write1");
    wait_idle();
    send(2'd2, 2'd1, 21'h00101, 2'd1, 32'h0000_C33C, 0, "R3 R4 write2");
    wait_idle();
    send(2'd0, 2'd1, 21'h1FFFE, 2'd2, 32'hA1B2_C3D4, 0, "R3 write4");
    wait_idle();
    send(2'd3, 2'd2, 21'h0, 2'd0, 32'h0, 0, "R5 poll");
    wait_idle();
    send(2'd1, 2'd3, 21'h0, 2'd0, 32'h0, 0, "R6 term");
    wait_idle();

    // R12: done and next accept in the same cycle
    send(2'd2, 2'd1, 21'h0AAAA, 2'd2, 32'h0102_0304, 1, "R12 b2b first");
    send(2'd1, 2'd0, 21'h15555, 2'd1, 32'h0, 0, "R12 b2b second");
    wait_idle();

    // R11: request while busy is ignored
    send(2'd0, 2'd2, 21'h0, 2'd0, 32'h0, 0, "R11 busy frame");
    repeat (6) @(negedge clk);
    chk(!req_ready, "R11 ready while busy", $sformatf("%0b", req_ready), "0");
    req_id = 2'd3; req_op = 2'd3; req_valid = 1'b1;
    repeat (5) @(negedge clk);
    req_valid = 1'b0;
    wait_idle();
    repeat (20) @(negedge clk);

    chk(frames_seen == frames_sent && q.size() == 0, "R11 frame count",
        $sformatf("%0d", frames_seen), $sformatf("%0d", frames_sent));
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule